// File: doc/BRIEF.md
# Integer ALU with flag update

This block is the integer execution stage of a 32-bit processor pipeline. Each cycle in which `issue_i` is high it applies one operation to a register operand pair (or to a register and an immediate) and returns the result. It also returns a write strobe for the destination register and the new four-bit condition nibble (zero, sign, overflow, carry) with a strobe telling whether that nibble is to be committed. The operations are move, add, subtract, compare, AND, OR, XOR, NOT, three logic forms with a zero-extended 16-bit immediate, a set-on-flag-match, and logical left, logical right and arithmetic right shifts. The shift count comes from a register or from a 5-bit immediate.

The datapath is combinational. The only state is the condition nibble, which is held in a small register inside the block. It loads on the clock edge that ends a cycle with `flag_we_o` high, and its current value is presented on `flags_o`. The set-on-flag operation reads that register, and the logic operations use it to keep carry unchanged. Register file reads and writes, instruction decoding and floating point are done elsewhere; the decoder supplies `op_i`, the operands and the immediate directly.

Top module: `alu_core`

## Requirements
- R1: The condition nibble has zero in bit 0, sign in bit 1, overflow in bit 2 and carry in bit 3. `flags_o` resets to 0 and, on a clock edge where `flag_we_o` is high, takes the value `flags_next_o` had in that cycle; otherwise it holds.
- R2: ADD (op 1) yields b + s, where s is `a_i` or the sign-extended 5-bit immediate. Carry is bit 32 of the 33-bit unsigned sum, overflow is two's-complement signed overflow, and zero and sign follow the result.
- R3: SUB (op 2) yields b − s, with carry set on unsigned borrow and overflow set on signed overflow. CMP (op 3) updates all four flags exactly as SUB does, but holds `rd_we_o` low.
- R4: OR (7), AND (8), XOR (9) combine `a_i` with `b_i`, and NOT (10) inverts `a_i`. They set zero and sign from the result, clear overflow, and leave carry at its current `flags_o` value.
- R5: ORI (12), ANDI (13), XORI (14) combine `a_i` with `imm_i` zero-extended to 32 bits. They set zero from the result, clear sign and overflow, and leave carry unchanged.
- R6: SHL (4), SHR (5) and SAR (6) shift `b_i`. The count is the low 5 bits of `imm_i` when `imm5_sel_i` is 1, else the low 5 bits of `a_i`. Overflow is always cleared. A count of 0 returns `b_i` unchanged with carry 0, and zero and sign taken from `b_i`.
- R7: For a nonzero count, carry is the last bit shifted out of the 32-bit word, SHR fills with zeros, and SAR fills with copies of bit 31. SHL fills with zeros, and its carry is bit 32−n of the operand for a count n.
- R8: SETF (op 11) returns 1 when `imm_i[3:0]` equals `flags_o` and returns 0 otherwise. It does not write the flags.
- R9: With `imm5_sel_i` = 1, the second operand of MOV, ADD and CMP is `imm_i[4:0]` sign-extended to 32 bits.
- R10: MOV (op 0) returns the selected operand and does not write the flags. For an issued operation, `rd_we_o` is high except for CMP, and `flag_we_o` is high except for MOV and SETF. With `issue_i` low, both strobes are low and `flags_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An operation is executed this cycle |
| op_i | input | 4 | Operation select (codes in R2 to R10) |
| a_i | input | 32 | First register operand (source, shift count or logic source) |
| b_i | input | 32 | Second register operand (destination's old value, shifted value) |
| imm_i | input | 16 | Immediate field (5-bit or 16-bit forms) |
| imm5_sel_i | input | 1 | Use the 5-bit immediate instead of `a_i` for MOV/ADD/CMP/shift count |
| result_o | output | 32 | Operation result |
| rd_we_o | output | 1 | Destination register is to be written |
| flag_we_o | output | 1 | Condition nibble is to be committed |
| flags_next_o | output | 4 | New condition nibble |
| flags_o | output | 4 | Current registered condition nibble |

## Verification
The only internal state is the condition nibble. If it goes wrong, `flags_o` shows the error in the cycle after the bad commit. The next SETF result then carries the error, and so does the carry of any logic operation that follows. A fault in the datapath shows at once on `result_o` or `flags_next_o` in the same cycle as the operation. The bench therefore compares every port in every issued cycle. It weights the carry-hold and set-on-flag cases, because these are the only paths through which a stale nibble reaches the outputs.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_MOV  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_CMP  = 4'd3,
    OP_SHL  = 4'd4,
    OP_SHR  = 4'd5,
    OP_SAR  = 4'd6,
    OP_OR   = 4'd7,
    OP_AND  = 4'd8,
    OP_XOR  = 4'd9,
    OP_NOT  = 4'd10,
    OP_SETF = 4'd11,
    OP_ORI  = 4'd12,
    OP_ANDI = 4'd13,
    OP_XORI = 4'd14
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;

  typedef enum logic [1:0] {
    LG_OR  = 2'd0,
    LG_AND = 2'd1,
    LG_XOR = 2'd2,
    LG_NOT = 2'd3
  } logic_kind_e;

  localparam int FLAG_W  = 4;
  localparam int FLG_Z   = 0;
  localparam int FLG_S   = 1;
  localparam int FLG_OV  = 2;
  localparam int FLG_CY  = 3;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs_i,
  input  logic [W-1:0] rhs_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W:0] wide;

  always_comb begin
    if (sub_i) wide = {1'b0, lhs_i} - {1'b0, rhs_i};
    else       wide = {1'b0, lhs_i} + {1'b0, rhs_i};
  end

  assign sum_o   = wide[W-1:0];
  assign carry_o = wide[W];
  // signed overflow: operand signs agree (add) or differ (sub) and result sign departs from lhs
  assign ovf_o   = (sub_i ? (lhs_i[W-1] != rhs_i[W-1]) : (lhs_i[W-1] == rhs_i[W-1]))
                   && (wide[W-1] != lhs_i[W-1]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int W  = 32,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [CW-1:0] cnt_i,
  input  shift_kind_e   kind_i,
  output logic [W-1:0]  res_o,
  output logic          carry_o
);
  logic [W-1:0] rev_in;
  logic [W-1:0] src;
  logic         fill;
  logic [W:0]   stg [0:CW];
  logic [W-1:0] rev_out;

  // a left shift runs through the right-shift barrel on a bit-reversed word
  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign rev_in[i] = val_i[W-1-i];
  end

  assign src  = (kind_i == SH_LEFT) ? rev_in : val_i;
  assign fill = (kind_i == SH_RARI) ? val_i[W-1] : 1'b0;

  // one guard bit below the word catches the last bit shifted out
  assign stg[0] = {src, 1'b0};

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int SH = 2 ** k;
    assign stg[k+1] = cnt_i[k] ? {{SH{fill}}, stg[k][W:SH]} : stg[k];
  end

  for (genvar i = 0; i < W; i++) begin : g_rev_out
    assign rev_out[i] = stg[CW][W-i];
  end

  assign res_o   = (kind_i == SH_LEFT) ? rev_out : stg[CW][W:1];
  assign carry_o = stg[CW][0];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic_kind_e  kind_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (kind_i)
      LG_OR:   res_o = x_i | y_i;
      LG_AND:  res_o = x_i & y_i;
      LG_XOR:  res_o = x_i ^ y_i;
      default: res_o = ~x_i;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [FW-1:0] d_i,
  output logic [FW-1:0] q_o
);
  logic [FW-1:0] q_r;
  logic [FW-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W      = 32,
  parameter int IMM_W  = 16,
  parameter int SIMM_W = 5,
  localparam int CW    = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [3:0]       op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             imm5_sel_i,
  output logic [W-1:0]     result_o,
  output logic             rd_we_o,
  output logic             flag_we_o,
  output logic [FLAG_W-1:0] flags_next_o,
  output logic [FLAG_W-1:0] flags_o
);
  alu_op_e         op;
  logic [W-1:0]    simm_ext;
  logic [W-1:0]    zimm_ext;
  logic [W-1:0]    src_opnd;
  logic [CW-1:0]   sh_cnt;
  logic            is_sub;
  logic            is_logic_imm;
  logic            is_logic_reg;
  logic            is_shift;
  logic [W-1:0]    as_sum;
  logic            as_cy;
  logic            as_ov;
  shift_kind_e     sh_kind;
  logic [W-1:0]    sh_res;
  logic            sh_cy;
  logic_kind_e     lg_kind;
  logic [W-1:0]    lg_x;
  logic [W-1:0]    lg_y;
  logic [W-1:0]    lg_res;
  logic [W-1:0]    res;
  logic            wr_rd;
  logic            wr_flg;
  logic [FLAG_W-1:0] fnext;

  assign op       = alu_op_e'(op_i);
  assign simm_ext = {{(W-SIMM_W){imm_i[SIMM_W-1]}}, imm_i[SIMM_W-1:0]};
  assign zimm_ext = {{(W-IMM_W){1'b0}}, imm_i};
  assign src_opnd = imm5_sel_i ? simm_ext : a_i;
  assign sh_cnt   = imm5_sel_i ? imm_i[CW-1:0] : a_i[CW-1:0];

  assign is_sub       = (op == OP_SUB) || (op == OP_CMP);
  assign is_logic_imm = (op == OP_ORI) || (op == OP_ANDI) || (op == OP_XORI);
  assign is_logic_reg = (op == OP_OR) || (op == OP_AND) || (op == OP_XOR) || (op == OP_NOT);
  assign is_shift     = (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);

  alu_addsub #(.W(W)) u_addsub (
    .lhs_i   (b_i),
    .rhs_i   (src_opnd),
    .sub_i   (is_sub),
    .sum_o   (as_sum),
    .carry_o (as_cy),
    .ovf_o   (as_ov)
  );

  always_comb begin
    unique case (op)
      OP_SHL:  sh_kind = SH_LEFT;
      OP_SAR:  sh_kind = SH_RARI;
      default: sh_kind = SH_RLOG;
    endcase
  end

  alu_shifter #(.W(W)) u_shift (
    .val_i   (b_i),
    .cnt_i   (sh_cnt),
    .kind_i  (sh_kind),
    .res_o   (sh_res),
    .carry_o (sh_cy)
  );

  always_comb begin
    unique case (op)
      OP_OR,  OP_ORI:  lg_kind = LG_OR;
      OP_AND, OP_ANDI: lg_kind = LG_AND;
      OP_XOR, OP_XORI: lg_kind = LG_XOR;
      default:         lg_kind = LG_NOT;
    endcase
  end

  assign lg_x = is_logic_imm ? zimm_ext : a_i;
  assign lg_y = is_logic_imm ? a_i : b_i;

  alu_logic #(.W(W)) u_logic (
    .x_i    (lg_x),
    .y_i    (lg_y),
    .kind_i (lg_kind),
    .res_o  (lg_res)
  );

  always_comb begin
    res    = '0;
    wr_rd  = 1'b1;
    wr_flg = 1'b1;
    fnext  = flags_o;
    if (op == OP_MOV) begin
      res    = src_opnd;
      wr_flg = 1'b0;
    end else if ((op == OP_ADD) || is_sub) begin
      res          = as_sum;
      wr_rd        = (op != OP_CMP);
      fnext[FLG_CY] = as_cy;
      fnext[FLG_OV] = as_ov;
    end else if (is_shift) begin
      res           = sh_res;
      fnext[FLG_CY] = sh_cy;
      fnext[FLG_OV] = 1'b0;
    end else if (is_logic_reg || is_logic_imm) begin
      res           = lg_res;
      fnext[FLG_OV] = 1'b0;
    end else if (op == OP_SETF) begin
      res    = {{(W-1){1'b0}}, (imm_i[FLAG_W-1:0] == flags_o)};
      wr_flg = 1'b0;
    end else begin
      wr_rd  = 1'b0;
      wr_flg = 1'b0;
    end
    fnext[FLG_Z] = (res == '0);
    fnext[FLG_S] = res[W-1] && !is_logic_imm;
  end

  assign result_o     = res;
  assign rd_we_o      = issue_i && wr_rd;
  assign flag_we_o    = issue_i && wr_flg;
  assign flags_next_o = fnext;

  alu_flag_reg #(.FW(FLAG_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (flag_we_o),
    .d_i    (flags_next_o),
    .q_o    (flags_o)
  );

  p_flag_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_o |=> (flags_o == $past(flags_next_o)));

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_o |=> $stable(flags_o));

  p_cmp_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op == OP_CMP) |-> (!rd_we_o && flag_we_o));

  p_logic_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && is_logic_reg) |-> (!flags_next_o[FLG_OV] && flags_next_o[FLG_CY] == flags_o[FLG_CY]));

  p_imm_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && is_logic_imm) |-> (!flags_next_o[FLG_S] && !flags_next_o[FLG_OV]));

  p_shift_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && is_shift && sh_cnt == '0) |-> (result_o == b_i && !flags_next_o[FLG_CY]));

  p_sar_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op == OP_SAR) |-> (result_o[W-1] == b_i[W-1]));

  p_setf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op == OP_SETF) |-> (result_o[W-1:1] == '0 && !flag_we_o));
endmodule

// File: tb/sim_alu_core.sv
`timescale 1ns/1ps
module sim_alu_core;
  logic        clk;
  logic        rst_n;
  logic        issue_i;
  logic [3:0]  op_i;
  logic [31:0] a_i;
  logic [31:0] b_i;
  logic [15:0] imm_i;
  logic        imm5_sel_i;
  logic [31:0] result_o;
  logic        rd_we_o;
  logic        flag_we_o;
  logic [3:0]  flags_next_o;
  logic [3:0]  flags_o;

  int vectors = 0;
  int errors  = 0;
  logic [3:0] mflags;
  logic [31:0] lfsr = 32'hACE1_2345;

  alu_core u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .imm5_sel_i(imm5_sel_i),
    .result_o(result_o), .rd_we_o(rd_we_o), .flag_we_o(flag_we_o),
    .flags_next_o(flags_next_o), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish (actual hang, expected completion)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  function automatic logic [31:0] next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  // behavioural reference of the requirements
  task automatic model(input logic iss, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] imm, input logic sel,
                       output logic [31:0] res, output logic rwe, output logic fwe,
                       output logic [3:0] fn);
    logic [31:0] s;
    longint sr;
    int cnt;
    logic cy, ov, z, sg;
    logic [31:0] v;
    s   = sel ? {{27{imm[4]}}, imm[4:0]} : a;
    cy  = mflags[3];
    ov  = mflags[2];
    res = 0; rwe = 1; fwe = 1;
    case (op)
      0: begin res = s; fwe = 0; end
      1: begin
        res = b + s;
        cy  = ({1'b0, b} + {1'b0, s}) > 33'h0_FFFF_FFFF;
        sr  = longint'($signed(b)) + longint'($signed(s));
        ov  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      2, 3: begin
        res = b - s;
        cy  = b < s;
        sr  = longint'($signed(b)) - longint'($signed(s));
        ov  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        if (op == 3) rwe = 0;
      end
      4, 5, 6: begin
        cnt = sel ? int'(imm[4:0]) : int'(a[4:0]);
        v = b; cy = 0; ov = 0;
        for (int i = 0; i < cnt; i++) begin
          if (op == 4) begin cy = v[31]; v = v << 1; end
          else begin cy = v[0]; v = {(op == 6) ? v[31] : 1'b0, v[31:1]}; end
        end
        res = v;
      end
      7:  begin res = a | b; ov = 0; end
      8:  begin res = a & b; ov = 0; end
      9:  begin res = a ^ b; ov = 0; end
      10: begin res = ~a;    ov = 0; end
      11: begin res = (imm[3:0] == mflags) ? 32'd1 : 32'd0; fwe = 0; end
      12: begin res = a | {16'h0, imm}; ov = 0; end
      13: begin res = a & {16'h0, imm}; ov = 0; end
      14: begin res = a ^ {16'h0, imm}; ov = 0; end
      default: begin rwe = 0; fwe = 0; end
    endcase
    z  = (res == 0);
    sg = res[31] && !(op >= 12);
    fn = {cy, ov, sg, z};
    if (!iss) begin rwe = 0; fwe = 0; end
  endtask

  task automatic apply(input logic iss, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] imm, input logic sel,
                       input string req);
    logic [31:0] er;
    logic erw, efw;
    logic [3:0] efn;
    @(negedge clk);
    issue_i = iss; op_i = op; a_i = a; b_i = b; imm_i = imm; imm5_sel_i = sel;
    #1;
    model(iss, op, a, b, imm, sel, er, erw, efw, efn);
    vectors++;
    if (flags_o !== mflags) begin
      errors++;
      $display("FAIL %s flags_o: actual %h expected %h", req, flags_o, mflags);
    end else if (iss && erw && result_o !== er) begin
      errors++;
      $display("FAIL %s op %0d result: actual %h expected %h", req, op, result_o, er);
    end else if (iss && op == 11 && result_o !== er) begin
      errors++;
      $display("FAIL %s setf result: actual %h expected %h", req, result_o, er);
    end else if (rd_we_o !== erw || flag_we_o !== efw) begin
      errors++;
      $display("FAIL %s op %0d strobes: actual %b%b expected %b%b", req, op, rd_we_o, flag_we_o, erw, efw);
    end else if (efw && flags_next_o !== efn) begin
      errors++;
      $display("FAIL %s op %0d flags_next: actual %h expected %h", req, op, flags_next_o, efn);
    end
    @(posedge clk);
    if (efw) mflags = efn;
  endtask

  initial begin
    rst_n = 0; issue_i = 0; op_i = 0; a_i = 0; b_i = 0; imm_i = 0; imm5_sel_i = 0;
    mflags = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    apply(0, 1, 32'h0, 32'h0, 16'h0, 0, "R1 reset");
    // R2 add: overflow, carry, zero
    apply(1, 1, 32'h1, 32'h7FFF_FFFF, 16'h0, 0, "R2 add ovf");
    apply(1, 1, 32'h1, 32'hFFFF_FFFF, 16'h0, 0, "R2 add carry zero");
    apply(1, 1, 32'h5, 32'h3, 16'h0, 0, "R2 add plain");
    // R9 sign-extended imm5 for add, mov, cmp
    apply(1, 1, 32'h0, 32'h10, 16'h001F, 1, "R9 add imm -1");
    apply(1, 0, 32'h0, 32'h0, 16'h0010, 1, "R9 mov imm -16");
    apply(1, 3, 32'h0, 32'hFFFF_FFF0, 16'h0010, 1, "R9 cmp imm equal");
    // R3 sub and cmp
    apply(1, 2, 32'h1, 32'h0, 16'h0, 0, "R3 sub borrow");
    apply(1, 2, 32'h1, 32'h8000_0000, 16'h0, 0, "R3 sub ovf");
    apply(1, 3, 32'h9, 32'h4, 16'h0, 0, "R3 cmp no write");
    // R4 logic keeps carry (carry currently set by the cmp borrow)
    apply(1, 8, 32'hF0F0_0000, 32'hFF00_0000, 16'h0, 0, "R4 and carry hold");
    apply(1, 7, 32'h0, 32'h0, 16'h0, 0, "R4 or zero");
    apply(1, 9, 32'h1234_5678, 32'h1234_5678, 16'h0, 0, "R4 xor");
    apply(1, 10, 32'h7FFF_FFFF, 32'h0, 16'h0, 0, "R4 not");
    // R5 logic immediates clear sign
    apply(1, 12, 32'h8000_0000, 32'h0, 16'hFFFF, 0, "R5 ori sign cleared");
    apply(1, 13, 32'hFFFF_FFFF, 32'h0, 16'h0000, 0, "R5 andi zero");
    apply(1, 14, 32'h8000_00FF, 32'h0, 16'h00F0, 0, "R5 xori");
    // R6 shift count zero and masking
    apply(1, 2, 32'h1, 32'h0, 16'h0, 0, "R3 set carry");
    apply(1, 4, 32'h0, 32'h8000_0001, 16'h0, 1, "R6 shl count0 clears carry");
    apply(1, 6, 32'h20, 32'h8000_0000, 16'h0, 0, "R6 sar reg count 32 masked to 0");
    apply(1, 5, 32'h21, 32'h3, 16'h0, 0, "R6 shr reg count 33 masked to 1");
    // R7 last bit out and fill
    apply(1, 4, 32'h0, 32'h8000_0000, 16'h0001, 1, "R7 shl carry");
    apply(1, 4, 32'h0, 32'h0001_0000, 16'h0010, 1, "R7 shl 16");
    apply(1, 5, 32'h0, 32'h8000_0000, 16'h001F, 1, "R7 shr 31");
    apply(1, 6, 32'h0, 32'h8000_0040, 16'h0007, 1, "R7 sar fill");
    apply(1, 6, 32'h0, 32'hF000_0000, 16'h001F, 1, "R7 sar 31");
    // R8 setf match and mismatch
    apply(1, 11, 32'h0, 32'h0, {12'h0, mflags}, 1, "R8 setf match");
    apply(1, 11, 32'h0, 32'h0, {11'h0, 1'b1, ~mflags}, 1, "R8 setf mismatch");
    // R10 idle cycles and mov
    apply(0, 1, 32'h7FFF_FFFF, 32'h1, 16'h0, 0, "R10 no issue");
    apply(1, 0, 32'hDEAD_BEEF, 32'h0, 16'h0, 0, "R10 mov reg");
    apply(1, 11, 32'h0, 32'h0, {12'h0, mflags}, 1, "R10 flags held after mov");
    // mixed patterns
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ra, rb, rc;
      ra = next_rand(); rb = next_rand(); rc = next_rand();
      if (rc[7:4] == 15) rc[7:4] = 4'd11;
      apply(rc[8] | rc[9], rc[7:4], (rc[3:2] == 0) ? 32'h8000_0000 : ra,
            (rc[1:0] == 0) ? 32'h7FFF_FFFF : rb, rc[31:16], rc[10], "R2 R3 R4 R7 mixed");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule